// File: doc/BRIEF.md
# Thread Block Dispatcher with Resource Admission

This block hands the thread blocks of a single kernel launch to a small array of streaming multiprocessors (SMs). A launch is started with a one-cycle pulse that carries the block count, the threads in each block, the registers each thread needs and the shared memory each block needs. The dispatcher then offers blocks one at a time on a valid/ready output. Each offer names a block id and a target SM.

For every SM the block keeps a ledger of resident threads, resident blocks, reserved registers, reserved shared memory and resident warps. A block is placed only on an SM where all of these limits still hold after adding the whole block. A block that fits nowhere waits, with every later block behind it, until a completion notice for some SM returns one block's worth of resources. Resources are reserved on the cycle a block is offered. The per-SM warp counts are driven out continuously, so occupancy (resident warps over the 64-warp maximum) can be monitored.

A launch ends with a done pulse once every block has been handed out and every completion has come back. A launch whose single block could never fit an empty SM is refused with an error pulse.

Top module: `block_dispatcher`

## Requirements
- R1: After reset the dispatcher is idle: `running`, `disp_valid`, `launch_done` and `launch_err` are low, and every per-SM warp count is zero.
- R2: No SM ever holds more than 1536 resident threads; a block is placed only if all of its threads fit in the SM's remaining thread capacity.
- R3: No SM ever holds more than 8 resident blocks, even when thread capacity remains.
- R4: A block reserves threads × registers-per-thread registers out of a 16384-register budget per SM, and it is not placed if that product exceeds the SM's remaining registers by any amount.
- R5: A block reserves its shared-memory demand out of 49152 bytes per SM, and it is not placed if the SM's remaining shared memory is smaller than the demand.
- R6: Block ids are offered in increasing order from 0. An offer holds its id and SM stable until it is accepted (`disp_valid` and `disp_ready` both high). The SM chosen is the first one with room, scanning upward with wrap-around from the SM after the previous recipient; the first block of a launch scans from SM 0.
- R7: Blocks that fit nowhere are held back and are offered later, once completions return enough resources.
- R8: A completion (`comp_valid` with `comp_sm`) returns one block's worth of every resource on that SM. A completion naming an SM with no resident block has no effect. A completion and a new reservation on the same SM in the same cycle both take effect.
- R9: `active_warps` holds, for each SM in a 7-bit field (SM i at bits 7i+6..7i), the sum over its resident blocks of ceil(threads/32). No SM ever exceeds 64 warps.
- R10: One cycle after the last outstanding block completes, `launch_done` pulses for one cycle, `running` falls, and all warp counts are zero. A launch of zero blocks pulses `launch_done` without dispatching anything.
- R11: A launch with zero threads per block, or whose single block exceeds an empty SM in threads, warps, registers or shared memory, pulses `launch_err`, dispatches nothing and leaves the dispatcher idle.
- R12: A `launch_start` pulse while a launch is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_start | input | 1 | One-cycle launch request, taken only while idle |
| launch_blocks | input | 16 | Number of thread blocks in the launch |
| launch_threads | input | 11 | Threads per block |
| launch_regs | input | 8 | Registers per thread |
| launch_smem | input | 17 | Shared-memory bytes per block |
| running | output | 1 | A launch is in progress |
| launch_done | output | 1 | One-cycle pulse when the launch has fully drained |
| launch_err | output | 1 | One-cycle pulse when a launch is refused |
| disp_valid | output | 1 | A block offer is present |
| disp_ready | input | 1 | The receiver accepts the offer |
| disp_block_id | output | 16 | Id of the offered block |
| disp_sm | output | 2 | SM the offered block goes to |
| comp_valid | input | 1 | A block on `comp_sm` has finished |
| comp_sm | input | 2 | SM whose block finished |
| active_warps | output | 28 | Resident warps per SM, 7 bits per SM |

## Verification
The case that needs care is a completion arriving on the same SM and in the same cycle that a new block is reserved there, so that both the release and the reservation change that SM's ledger at one edge. The bench provokes this with random acceptance and completion rates on small launches, which fill the SMs so that new blocks keep landing where completions are landing. It judges the result through the per-SM warp counts and the next SM choice, both compared each cycle with a model that applies the release and the reservation in the order stated in R8.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    localparam int NSM      = 4;
    localparam int THR_MAX  = 1536;
    localparam int BLK_MAX  = 8;
    localparam int REG_MAX  = 16384;
    localparam int SMEM_MAX = 49152;
    localparam int WARP_T   = 32;
    localparam int WARP_MAX = 64;

    localparam int TW  = $clog2(THR_MAX + 1);
    localparam int WW  = $clog2(WARP_MAX + 1);
    localparam int BW  = $clog2(BLK_MAX + 1);
    localparam int RW  = $clog2(REG_MAX + 1);
    localparam int SW  = $clog2(SMEM_MAX + 1);
    localparam int SDW = SW + 1;
    localparam int RPW = 8;
    localparam int DRW = TW + RPW;
    localparam int IDW = 16;

    typedef enum logic {PH_IDLE, PH_RUN} phase_t;

    // what one block asks of an SM
    typedef struct packed {
        logic [TW-1:0]  thr;
        logic [WW-1:0]  wrp;
        logic [DRW-1:0] regs;
        logic [SDW-1:0] smem;
    } demand_t;

    // what an SM has handed out
    typedef struct packed {
        logic [TW-1:0] thr;
        logic [BW-1:0] blk;
        logic [WW-1:0] wrp;
        logic [RW-1:0] regs;
        logic [SW-1:0] smem;
    } usage_t;

    function automatic demand_t mk_demand(logic [TW-1:0] thr,
                                          logic [RPW-1:0] rpt,
                                          logic [SDW-1:0] sm);
        demand_t d;
        d.thr  = thr;
        d.wrp  = WW'((32'(thr) + WARP_T - 1) / WARP_T);
        d.regs = DRW'(thr) * DRW'(rpt);
        d.smem = sm;
        return d;
    endfunction

    // true when one more block of demand d still respects every limit
    function automatic logic fits_in(usage_t u, demand_t d,
                                     int thr_lim, int blk_lim, int reg_lim,
                                     int smem_lim, int warp_lim);
        return (32'(u.thr)  + 32'(d.thr)  <= thr_lim)  &&
               (32'(u.blk)  < blk_lim)                 &&
               (32'(u.wrp)  + 32'(d.wrp)  <= warp_lim) &&
               (32'(u.regs) + 32'(d.regs) <= reg_lim)  &&
               (32'(u.smem) + 32'(d.smem) <= smem_lim);
    endfunction

endpackage

// File: rtl/sm_ledger.sv
module sm_ledger
    import tbd_pkg::*;
#(
    parameter int THR_LIM  = THR_MAX,
    parameter int BLK_LIM  = BLK_MAX,
    parameter int REG_LIM  = REG_MAX,
    parameter int SMEM_LIM = SMEM_MAX,
    parameter int WARP_LIM = WARP_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  demand_t       dem,
    input  logic          alloc,
    input  logic          release_req,
    output logic          fits,
    output logic          occupied,
    output logic [WW-1:0] warps
);

    usage_t used_q, used_d;
    logic   rel_ok;

    assign occupied = (used_q.blk != '0);
    assign rel_ok   = release_req && occupied;
    assign fits     = fits_in(used_q, dem, THR_LIM, BLK_LIM, REG_LIM, SMEM_LIM, WARP_LIM);
    assign warps    = used_q.wrp;

    always_comb begin
        used_d = used_q;
        if (alloc) begin
            used_d.thr  = used_d.thr  + dem.thr;
            used_d.blk  = used_d.blk  + BW'(1);
            used_d.wrp  = used_d.wrp  + dem.wrp;
            used_d.regs = used_d.regs + RW'(dem.regs);
            used_d.smem = used_d.smem + SW'(dem.smem);
        end
        if (rel_ok) begin
            used_d.thr  = used_d.thr  - dem.thr;
            used_d.blk  = used_d.blk  - BW'(1);
            used_d.wrp  = used_d.wrp  - dem.wrp;
            used_d.regs = used_d.regs - RW'(dem.regs);
            used_d.smem = used_d.smem - SW'(dem.smem);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) used_q <= '0;
        else     used_q <= used_d;
    end

    // R2
    thr_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(used_q.thr) <= THR_LIM) else $error("thread capacity exceeded");
    // R3
    blk_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(used_q.blk) <= BLK_LIM) else $error("block slots exceeded");
    // R4
    reg_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(used_q.regs) <= REG_LIM) else $error("register budget exceeded");
    // R5
    smem_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(used_q.smem) <= SMEM_LIM) else $error("shared memory exceeded");
    // R9
    warp_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(used_q.wrp) <= WARP_LIM) else $error("warp capacity exceeded");
    // R2
    alloc_fit_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |-> fits) else $error("reservation without room");
    // R8
    empty_rel_chk: assert property (@(posedge clk) disable iff (rst)
        release_req && !occupied && !alloc |=> used_q.blk == '0)
        else $error("completion on empty SM changed state");

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N   = 4,
    parameter int SMW = $clog2(N)
) (
    input  logic [N-1:0]   cand,
    input  logic [SMW-1:0] last,
    output logic           any,
    output logic [SMW-1:0] pick
);

    // walk from farthest to nearest so the nearest candidate after last wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (cand[idx]) begin
                any  = 1'b1;
                pick = SMW'(idx);
            end
        end
    end

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
    import tbd_pkg::*;
#(
    parameter int NUM_SM   = NSM,
    parameter int THR_LIM  = THR_MAX,
    parameter int BLK_LIM  = BLK_MAX,
    parameter int REG_LIM  = REG_MAX,
    parameter int SMEM_LIM = SMEM_MAX,
    parameter int WARP_LIM = WARP_MAX
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        launch_start,
    input  logic [IDW-1:0]              launch_blocks,
    input  logic [TW-1:0]               launch_threads,
    input  logic [RPW-1:0]              launch_regs,
    input  logic [SDW-1:0]              launch_smem,
    output logic                        running,
    output logic                        launch_done,
    output logic                        launch_err,
    output logic                        disp_valid,
    input  logic                        disp_ready,
    output logic [IDW-1:0]              disp_block_id,
    output logic [$clog2(NUM_SM)-1:0]   disp_sm,
    input  logic                        comp_valid,
    input  logic [$clog2(NUM_SM)-1:0]   comp_sm,
    output logic [NUM_SM*WW-1:0]        active_warps
);

    localparam int SMW = $clog2(NUM_SM);
    localparam int OW  = IDW + 1;

    phase_t         phase_q;
    demand_t        dem_q, new_dem;
    usage_t         empty_u;
    logic [IDW-1:0] total_q, next_id_q, offer_id_q;
    logic [SMW-1:0] offer_sm_q, last_q, pick;
    logic [OW-1:0]  outst_q;
    logic           offer_v_q, done_q, err_q;
    logic           any_fit, take, load, rel_any, finish, oversize;
    logic [NUM_SM-1:0] fit_v, occ_v, alloc_v, rel_v;

    assign empty_u  = '0;
    assign new_dem  = mk_demand(launch_threads, launch_regs, launch_smem);
    assign oversize = (launch_threads == '0) ||
                      !fits_in(empty_u, new_dem, THR_LIM, BLK_LIM, REG_LIM, SMEM_LIM, WARP_LIM);

    assign take    = offer_v_q && disp_ready;
    assign load    = (phase_q == PH_RUN) && (!offer_v_q || take) &&
                     (next_id_q < total_q) && any_fit;
    assign rel_any = (phase_q == PH_RUN) && comp_valid && occ_v[comp_sm];
    assign finish  = (phase_q == PH_RUN) && (next_id_q == total_q) &&
                     !offer_v_q && (outst_q == '0);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SM; gi++) begin : g_sm
            assign alloc_v[gi] = load && (pick == SMW'(gi));
            assign rel_v[gi]   = (phase_q == PH_RUN) && comp_valid && (comp_sm == SMW'(gi));
            sm_ledger #(
                .THR_LIM(THR_LIM), .BLK_LIM(BLK_LIM), .REG_LIM(REG_LIM),
                .SMEM_LIM(SMEM_LIM), .WARP_LIM(WARP_LIM)
            ) u_ledger (
                .clk        (clk),
                .rst        (rst),
                .dem        (dem_q),
                .alloc      (alloc_v[gi]),
                .release_req(rel_v[gi]),
                .fits       (fit_v[gi]),
                .occupied   (occ_v[gi]),
                .warps      (active_warps[gi*WW +: WW])
            );
        end
    endgenerate

    rr_pick #(.N(NUM_SM), .SMW(SMW)) u_pick (
        .cand(fit_v),
        .last(last_q),
        .any (any_fit),
        .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            dem_q      <= '0;
            total_q    <= '0;
            next_id_q  <= '0;
            offer_v_q  <= 1'b0;
            offer_id_q <= '0;
            offer_sm_q <= '0;
            last_q     <= SMW'(NUM_SM - 1);
            outst_q    <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (launch_start) begin
                        dem_q <= new_dem;
                        if (oversize) begin
                            err_q <= 1'b1;
                        end else if (launch_blocks == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q   <= PH_RUN;
                            total_q   <= launch_blocks;
                            next_id_q <= '0;
                            last_q    <= SMW'(NUM_SM - 1);
                        end
                    end
                end
                default: begin
                    if (load) begin
                        offer_v_q  <= 1'b1;
                        offer_id_q <= next_id_q;
                        offer_sm_q <= pick;
                        last_q     <= pick;
                        next_id_q  <= next_id_q + IDW'(1);
                    end else if (take) begin
                        offer_v_q <= 1'b0;
                    end
                    outst_q <= outst_q + OW'(load) - OW'(rel_any);
                    if (finish) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign running       = (phase_q == PH_RUN);
    assign launch_done   = done_q;
    assign launch_err    = err_q;
    assign disp_valid    = offer_v_q;
    assign disp_block_id = offer_id_q;
    assign disp_sm       = offer_sm_q;

    // R6
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_block_id) && $stable(disp_sm))
        else $error("offer changed before acceptance");
    // R6
    id_order_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid && disp_ready |=> !disp_valid || (disp_block_id == $past(disp_block_id) + IDW'(1)))
        else $error("block ids out of order");
    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        launch_err |-> !disp_valid && !running) else $error("refused launch is active");
    // R10
    done_drain_chk: assert property (@(posedge clk) disable iff (rst)
        launch_done |-> (active_warps == '0) && !disp_valid && !running)
        else $error("done with resources held");

endmodule

// File: tb/block_dispatcher_tb_top.sv
module block_dispatcher_tb_top;
    import tbd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int S = NSM;

    logic clk = 1'b0, rst = 1'b1;
    logic launch_start = 1'b0;
    logic [IDW-1:0] launch_blocks = '0;
    logic [TW-1:0]  launch_threads = '0;
    logic [RPW-1:0] launch_regs = '0;
    logic [SDW-1:0] launch_smem = '0;
    logic running, launch_done, launch_err, disp_valid;
    logic disp_ready = 1'b0;
    logic [IDW-1:0] disp_block_id;
    logic [1:0] disp_sm;
    logic comp_valid = 1'b0;
    logic [1:0] comp_sm = '0;
    logic [S*WW-1:0] active_warps;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_dispatcher dut_i (
        .clk(clk), .rst(rst), .launch_start(launch_start), .launch_blocks(launch_blocks),
        .launch_threads(launch_threads), .launch_regs(launch_regs), .launch_smem(launch_smem),
        .running(running), .launch_done(launch_done), .launch_err(launch_err),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_block_id(disp_block_id),
        .disp_sm(disp_sm), .comp_valid(comp_valid), .comp_sm(comp_sm),
        .active_warps(active_warps)
    );

    int n_chk = 0, n_bad = 0;
    int m_thr[S], m_blk[S], m_regs[S], m_smem[S], m_wrp[S], issued[S];
    int d_thr, d_wrp, d_regs, d_smem, m_total, m_next, m_last;
    int rdy_rate, comp_rate, ghost_req, idle_cyc;
    bit prev_valid, prev_take, drv_cv, saw_done, saw_err;
    int drv_cs;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit mfits(int s);
        return (m_thr[s] + d_thr <= THR_MAX) && (m_blk[s] < BLK_MAX) &&
               (m_regs[s] + d_regs <= REG_MAX) && (m_smem[s] + d_smem <= SMEM_MAX) &&
               (m_wrp[s] + d_wrp <= WARP_MAX);
    endfunction

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // blocks held at once across all SMs when nothing completes
    function automatic int exp_cap(int thr, int rpt, int sm, int nb);
        int per;
        per = min2(THR_MAX / thr, BLK_MAX);
        per = min2(per, REG_MAX / (thr * rpt));
        per = min2(per, WARP_MAX / ((thr + WARP_T - 1) / WARP_T));
        if (sm > 0) per = min2(per, SMEM_MAX / sm);
        return min2(per * S, nb);
    endfunction

    task automatic step();
        bit rel;
        @(negedge clk);
        rel = drv_cv && (m_blk[drv_cs] > 0);
        if (disp_valid && (!prev_valid || prev_take)) begin
            int exp_sm, s;
            exp_sm = -1;
            for (int k = 1; k <= S; k++) begin
                int idx;
                idx = (m_last + k) % S;
                if (exp_sm < 0 && mfits(idx)) exp_sm = idx;
            end
            chk(int'(disp_block_id) == m_next, "R6 block id order", int'(disp_block_id), m_next);
            chk(int'(disp_sm) == exp_sm, "R6 round-robin SM (R2 R3 R4 R5 limits)", int'(disp_sm), exp_sm);
            s = int'(disp_sm);
            m_thr[s] += d_thr; m_blk[s] += 1; m_regs[s] += d_regs;
            m_smem[s] += d_smem; m_wrp[s] += d_wrp;
            m_last = s; m_next++; idle_cyc = 0;
        end else begin
            idle_cyc++;
        end
        if (rel) begin
            m_thr[drv_cs] -= d_thr; m_blk[drv_cs] -= 1; m_regs[drv_cs] -= d_regs;
            m_smem[drv_cs] -= d_smem; m_wrp[drv_cs] -= d_wrp;
        end
        for (int s = 0; s < S; s++)
            chk(int'(active_warps[s*WW +: WW]) == m_wrp[s], "R9 R8 warp count", int'(active_warps[s*WW +: WW]), m_wrp[s]);
        if (launch_done) begin
            int left;
            left = 0;
            for (int s = 0; s < S; s++) left += issued[s];
            saw_done = 1;
            chk(m_next == m_total && left == 0, "R10 done only after drain", m_next, m_total);
        end
        if (launch_err) saw_err = 1;
        // drive next cycle
        prev_valid = disp_valid;
        drv_cv = 0;
        if (ghost_req >= 0) begin
            drv_cv = 1; drv_cs = ghost_req; ghost_req = -1;
        end else if (int'($urandom % 100) < comp_rate) begin
            int st;
            st = int'($urandom % S);
            for (int k = 0; k < S; k++) begin
                int idx;
                idx = (st + k) % S;
                if (!drv_cv && issued[idx] > 0) begin
                    drv_cv = 1; drv_cs = idx; issued[idx]--;
                end
            end
        end
        comp_valid = drv_cv;
        comp_sm    = 2'(drv_cs);
        disp_ready = (int'($urandom % 100) < rdy_rate);
        prev_take  = disp_valid && disp_ready;
        if (prev_take) issued[int'(disp_sm)]++;
    endtask

    task automatic launch(int nb, int thr, int rpt, int sm);
        @(negedge clk);
        comp_valid = 0; drv_cv = 0; disp_ready = 0;
        d_thr = thr; d_wrp = (thr + WARP_T - 1) / WARP_T; d_regs = thr * rpt; d_smem = sm;
        m_total = nb; m_next = 0; m_last = S - 1; idle_cyc = 0;
        prev_valid = 0; prev_take = 0; saw_done = 0; saw_err = 0;
        launch_blocks = IDW'(nb); launch_threads = TW'(thr);
        launch_regs = RPW'(rpt); launch_smem = SDW'(sm);
        launch_start = 1;
        step();
        launch_start = 0;
    endtask

    task automatic run_to_done(string tag);
        int n;
        n = 0;
        while (!saw_done && n < 20000) begin
            step(); n++;
        end
        chk(saw_done, {tag, " R10 done pulse"}, int'(saw_done), 1);
        chk(m_next == m_total, {tag, " R7 all blocks dispatched"}, m_next, m_total);
        step();
        chk(!running, "R10 idle after done", int'(running), 0);
        for (int s = 0; s < S; s++)
            chk(active_warps[s*WW +: WW] == '0, "R10 warps back to zero", int'(active_warps[s*WW +: WW]), 0);
    endtask

    task automatic stall_case(string tag, int nb, int thr, int rpt, int sm);
        int cap;
        cap = exp_cap(thr, rpt, sm, nb);
        rdy_rate = 100; comp_rate = 0;
        launch(nb, thr, rpt, sm);
        while (idle_cyc < 20) step();
        chk(m_next == cap, {tag, " held at capacity"}, m_next, cap);
        comp_rate = 50;
        run_to_done(tag);
    endtask

    task automatic reject_case(string tag, int thr, int rpt, int sm);
        rdy_rate = 100; comp_rate = 0;
        launch(4, thr, rpt, sm);
        repeat (6) step();
        chk(saw_err, {tag, " R11 error pulse"}, int'(saw_err), 1);
        chk(m_next == 0 && !running, {tag, " R11 nothing dispatched"}, m_next, 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        ghost_req = -1; drv_cs = 0; rdy_rate = 100; comp_rate = 0;
        for (int s = 0; s < S; s++) begin
            m_thr[s] = 0; m_blk[s] = 0; m_regs[s] = 0; m_smem[s] = 0; m_wrp[s] = 0; issued[s] = 0;
        end
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(!running && !disp_valid && !launch_done && !launch_err, "R1 idle after reset", int'(running), 0);
        chk(active_warps == '0, "R1 warps zero after reset", int'(active_warps), 0);

        stall_case("R3 block slots", 40, 64, 4, 0);
        stall_case("R2 thread slots", 20, 512, 2, 0);
        stall_case("R4 registers", 30, 256, 12, 0);
        stall_case("R5 shared memory", 15, 32, 1, 20000);
        stall_case("R2 R4 R5 exact fit", 6, 1536, 10, 49152);

        reject_case("R11 threads", 1537, 1, 0);
        reject_case("R11 registers", 256, 65, 0);
        reject_case("R11 shared memory", 32, 1, 50000);
        reject_case("R11 zero threads", 0, 1, 0);

        // R10 zero-block launch
        launch(0, 32, 1, 0);
        repeat (3) step();
        chk(saw_done && m_next == 0, "R10 zero-block done", int'(saw_done), 1);

        // R8 completion on an empty SM is ignored
        rdy_rate = 100; comp_rate = 0;
        launch(2, 64, 1, 0);
        while (idle_cyc < 5) step();
        ghost_req = 3;
        repeat (3) step();
        chk(!saw_done && running, "R8 empty-SM completion ignored", int'(saw_done), 0);
        comp_rate = 60;
        run_to_done("R8");

        // R12 second launch while running is ignored
        rdy_rate = 80; comp_rate = 0;
        launch(10, 128, 8, 1000);
        repeat (4) step();
        launch_threads = TW'(1000); launch_blocks = IDW'(3); launch_start = 1;
        step();
        launch_start = 0;
        comp_rate = 40;
        run_to_done("R12 ignored relaunch");

        // constrained random launches
        for (int it = 0; it < 10; it++) begin
            int thr, rpt, sm, nb;
            thr = 1 + int'($urandom % 768);
            rpt = 1 + int'($urandom % 32);
            if (thr * rpt > REG_MAX) rpt = REG_MAX / thr;
            sm  = int'($urandom % 24000);
            nb  = 1 + int'($urandom % 48);
            rdy_rate = 50 + int'($urandom % 50);
            comp_rate = 20 + int'($urandom % 60);
            launch(nb, thr, rpt, sm);
            run_to_done("R6 R7 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule